// File: doc/BRIEF.md
# Proportional-Integral Tuning Filter with Split Coarse/Fine DAC Output

This block is the digital loop filter of a slow phase-locked loop that steers a controlled oscillator. Every accepted sample of a signed phase error is scaled by a power-of-two integral gain and summed into a wide, unsigned integrator. The same sample, scaled by an independent power-of-two proportional gain, is added to the top 24 bits of the integrator to form the tuning word that sets the oscillator voltage.

The tuning word is delivered through two DACs: a coarse DAC that stays put most of the time and a 16-bit fine DAC that follows the loop. A normalisation step re-centres the fine DAC at its midpoint and moves the remainder of the word into the coarse DAC without changing the total; afterwards only the fine DAC moves until it would leave its range, which triggers a new normalisation. Control inputs let the surrounding logic preload the integrator (for example with a value restored after power-up), hold the loop open, and request a normalisation.

Top module: `pll_tune_filter`

## Requirements
- R1: A 4-bit gain code c scales the phase error by 2^(c-8): code 0 is 1/256, code 8 is unity, code 15 is 128; scaling down is an arithmetic right shift that rounds toward minus infinity. Both gains use this coding.
- R2: A `load` pulse sets the integrator to `load_val` at the next clock edge, taking priority over accumulation and hold, and forces a normalisation at the edge after that.
- R3: While `hold` is high, `err_valid` is ignored: the integrator keeps its value and the proportional term is forced to zero.
- R4: On an edge with `err_valid` high and `hold` and `load` low, the integrator adds the integral-gained error and clamps the result to 0 .. 2^32-1 instead of wrapping.
- R5: The proportional term is registered from the same accepted sample; `tune_word` equals integrator bits 31:8 plus the proportional term, clamped to 0 .. 2^24-1.
- R6: After every edge, (coarse*256 + fine) mod 2^24 equals the `tune_word` present before that edge (one cycle of latency into the DACs).
- R7: A normalisation sets fine to {0x80, tune[7:0]} and coarse to (tune[23:8] - 0x80) mod 2^16, and raises `dac_renorm` for that one cycle.
- R8: When (tune - coarse*256) mod 2^24 is at most 0xFFFF and no normalisation is forced, only the fine DAC changes, taking that difference; `dac_renorm` stays low.
- R9: A normalisation happens automatically when that difference exceeds 0xFFFF, and whenever `norm_req` is high at an edge.
- R10: After reset the integrator and proportional term are zero, `tune_word` is 0, fine is 0x8000, coarse is 0xFF80 and `dac_renorm` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Phase error sample strobe |
| err | input | 16 | Signed phase error |
| igain_sel | input | 4 | Integral gain code |
| pgain_sel | input | 4 | Proportional gain code |
| hold | input | 1 | Open the loop |
| load | input | 1 | Preload the integrator |
| load_val | input | 32 | Preload value |
| norm_req | input | 1 | Force a normalisation |
| tune_word | output | 24 | Clamped tuning word |
| fine_dac | output | 16 | Fine DAC code |
| coarse_dac | output | 16 | Coarse DAC code |
| dac_renorm | output | 1 | Normalisation happened this cycle |

## Verification
The assertions watch, on every cycle, that the two DAC codes always sum to the previous tuning word, that a normalisation puts the fine DAC's upper byte at its midpoint, that the coarse DAC never moves except on a normalisation, and that hold, load and normalise requests have their effect one edge later. Only the bench scenarios can show the actual arithmetic: gain scaling and its rounding for every kind of code, clamping at both ends of the integrator and tuning word, and the exact fine-DAC values while tracking and at the moment it leaves its range.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
  // Gain code width and the code that means unity gain.
  localparam int GAIN_CODE_W = 4;
  localparam int GAIN_UNITY  = 8;
  // Number of tuning-word bits the fine DAC copies straight on a normalise.
  localparam int FINE_LOW_W  = 8;

  // Exponent of two selected by a gain code.
  function automatic int gain_exponent(input logic [GAIN_CODE_W-1:0] code);
    return int'(code) - GAIN_UNITY;
  endfunction
endpackage

// File: rtl/ptf_gain.sv
module ptf_gain
  import ptf_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0]        x,
  input  logic        [GAIN_CODE_W-1:0] sel,
  output logic signed [OUT_W-1:0]       y
);
  localparam int MAX_UP = (1 << GAIN_CODE_W) - 1 - GAIN_UNITY;
  localparam int NEED_W = IN_W + MAX_UP;

  logic signed [OUT_W-1:0] ext;

  // Power-of-two scaling: left shift for codes at or above unity, floor shift below.
  function automatic logic signed [OUT_W-1:0] scale(
    input logic signed [OUT_W-1:0] v,
    input logic [GAIN_CODE_W-1:0]  c
  );
    int e;
    e = gain_exponent(c);
    if (e >= 0) return v <<< e;
    else        return v >>> (-e);
  endfunction

  assign ext = {{(OUT_W-IN_W){x[IN_W-1]}}, x};
  assign y   = scale(ext, sel);

  initial begin
    if (OUT_W < NEED_W) $error("ptf_gain: OUT_W too small for the largest gain");
  end
endmodule

// File: rtl/ptf_integrator.sv
module ptf_integrator #(
  parameter int INT_W = 32,
  parameter int G_W   = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_en,
  input  logic                  load,
  input  logic [INT_W-1:0]      load_val,
  input  logic signed [G_W-1:0] gin,
  output logic [INT_W-1:0]      int_q,
  output logic                  sat_evt
);
  localparam int SUM_W = INT_W + 2;
  localparam logic [INT_W-1:0] INT_MAX = '1;

  logic signed [SUM_W-1:0] sum;
  logic [INT_W-1:0]        next_val;

  // Unsigned accumulator plus signed step, clamped to the accumulator range.
  function automatic logic [INT_W-1:0] clamp_add(
    input logic signed [SUM_W-1:0] s
  );
    if (s < 0)                           return '0;
    else if (s > $signed({2'b00, INT_MAX})) return INT_MAX;
    else                                 return s[INT_W-1:0];
  endfunction

  assign sum      = $signed({2'b00, int_q}) + $signed({{(SUM_W-G_W){gin[G_W-1]}}, gin});
  assign next_val = clamp_add(sum);
  assign sat_evt  = acc_en && (sum < 0 || sum > $signed({2'b00, INT_MAX}));

  always_ff @(posedge clk) begin
    if (!rst_n)      int_q <= '0;
    else if (load)   int_q <= load_val;
    else if (acc_en) int_q <= next_val;
  end
endmodule

// File: rtl/ptf_dac_split.sv
module ptf_dac_split
  import ptf_pkg::*;
#(
  parameter int TUNE_W = 24,
  parameter int FINE_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TUNE_W-1:0]             tune,
  input  logic                          force_norm,
  output logic [FINE_W-1:0]             fine_q,
  output logic [TUNE_W-FINE_LOW_W-1:0]  coarse_q,
  output logic                          renorm_q,
  output logic                          in_range
);
  localparam int COARSE_W = TUNE_W - FINE_LOW_W;
  localparam int HI_W     = FINE_W - FINE_LOW_W;
  localparam logic [HI_W-1:0]     MID_HI     = HI_W'(1) << (HI_W - 1);
  localparam logic [FINE_W-1:0]   FINE_MID   = {MID_HI, {FINE_LOW_W{1'b0}}};
  localparam logic [COARSE_W-1:0] COARSE_OFF = COARSE_W'(MID_HI);

  logic [TUNE_W-1:0] diff;
  logic              do_norm;

  // Residue the fine DAC must carry for the current coarse setting.
  function automatic logic [TUNE_W-1:0] residue(
    input logic [TUNE_W-1:0]   t,
    input logic [COARSE_W-1:0] c
  );
    return t - {c, {FINE_LOW_W{1'b0}}};
  endfunction

  assign diff     = residue(tune, coarse_q);
  assign in_range = (diff[TUNE_W-1:FINE_W] == '0);
  assign do_norm  = force_norm || !in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fine_q   <= FINE_MID;
      coarse_q <= '0 - COARSE_OFF;
      renorm_q <= 1'b0;
    end else if (do_norm) begin
      fine_q   <= {MID_HI, tune[FINE_LOW_W-1:0]};
      coarse_q <= tune[TUNE_W-1:FINE_LOW_W] - COARSE_OFF;
      renorm_q <= 1'b1;
    end else begin
      fine_q   <= diff[FINE_W-1:0];
      renorm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_tune_filter.sv
module pll_tune_filter
  import ptf_pkg::*;
#(
  parameter int ERR_W  = 16,
  parameter int INT_W  = 32,
  parameter int TUNE_W = 24,
  parameter int FINE_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          err_valid,
  input  logic signed [ERR_W-1:0]       err,
  input  logic [GAIN_CODE_W-1:0]        igain_sel,
  input  logic [GAIN_CODE_W-1:0]        pgain_sel,
  input  logic                          hold,
  input  logic                          load,
  input  logic [INT_W-1:0]              load_val,
  input  logic                          norm_req,
  output logic [TUNE_W-1:0]             tune_word,
  output logic [FINE_W-1:0]             fine_dac,
  output logic [TUNE_W-FINE_LOW_W-1:0]  coarse_dac,
  output logic                          dac_renorm
);
  localparam int G_W   = TUNE_W;
  localparam int SUM_W = TUNE_W + 2;
  localparam logic [TUNE_W-1:0] TUNE_MAX = '1;

  // Named internal events, visible to the bound checker.
  logic                     acc_en;
  logic                     load_q;
  logic                     force_norm;
  logic                     int_sat;
  logic                     fine_in_range;
  logic [INT_W-1:0]         int_q;
  logic signed [G_W-1:0]    gi;
  logic signed [G_W-1:0]    gp;
  logic signed [G_W-1:0]    p_q;

  function automatic logic [TUNE_W-1:0] tune_sum(
    input logic [INT_W-1:0]       i,
    input logic signed [G_W-1:0]  p
  );
    logic signed [SUM_W-1:0] s;
    s = $signed({2'b00, i[INT_W-1 -: TUNE_W]}) + $signed({{(SUM_W-G_W){p[G_W-1]}}, p});
    if (s < 0)                              return '0;
    else if (s > $signed({2'b00, TUNE_MAX})) return TUNE_MAX;
    else                                    return s[TUNE_W-1:0];
  endfunction

  assign acc_en     = err_valid && !hold && !load;
  assign force_norm = norm_req || load_q;

  ptf_gain #(.IN_W(ERR_W), .OUT_W(G_W)) u_igain (
    .x(err), .sel(igain_sel), .y(gi)
  );

  ptf_gain #(.IN_W(ERR_W), .OUT_W(G_W)) u_pgain (
    .x(err), .sel(pgain_sel), .y(gp)
  );

  ptf_integrator #(.INT_W(INT_W), .G_W(G_W)) u_int (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .load(load),
    .load_val(load_val), .gin(gi), .int_q(int_q), .sat_evt(int_sat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q    <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= load;
      if (hold)        p_q <= '0;
      else if (acc_en) p_q <= gp;
    end
  end

  assign tune_word = tune_sum(int_q, p_q);

  ptf_dac_split #(.TUNE_W(TUNE_W), .FINE_W(FINE_W)) u_split (
    .clk(clk), .rst_n(rst_n), .tune(tune_word), .force_norm(force_norm),
    .fine_q(fine_dac), .coarse_q(coarse_dac), .renorm_q(dac_renorm),
    .in_range(fine_in_range)
  );
endmodule

// File: rtl/ptf_checker.sv
module ptf_checker
  import ptf_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int TUNE_W = 24,
  parameter int FINE_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          hold,
  input logic                          load,
  input logic [INT_W-1:0]              load_val,
  input logic                          norm_req,
  input logic [INT_W-1:0]              int_q,
  input logic signed [TUNE_W-1:0]      p_q,
  input logic [TUNE_W-1:0]             tune_word,
  input logic [FINE_W-1:0]             fine_dac,
  input logic [TUNE_W-FINE_LOW_W-1:0]  coarse_dac,
  input logic                          dac_renorm
);
  localparam int HI_W = FINE_W - FINE_LOW_W;
  localparam logic [HI_W-1:0] MID_HI = HI_W'(1) << (HI_W - 1);

  logic [TUNE_W-1:0] dac_total;
  assign dac_total = {coarse_dac, {FINE_LOW_W{1'b0}}} + TUNE_W'(fine_dac);

  AST_SPLIT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dac_total == $past(tune_word)); // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> int_q == $past(int_q)); // R3

  AST_HOLD_PZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> p_q == '0); // R3

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> int_q == $past(load_val)); // R2

  AST_LOAD_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ##1 dac_renorm); // R2

  AST_NORM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    norm_req |=> dac_renorm); // R9

  AST_RENORM_MID: assert property (@(posedge clk) disable iff (!rst_n)
    dac_renorm |-> fine_dac[FINE_W-1:FINE_LOW_W] == MID_HI); // R7

  AST_COARSE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_renorm |-> $stable(coarse_dac)); // R8
endmodule

bind pll_tune_filter ptf_checker #(
  .INT_W(INT_W), .TUNE_W(TUNE_W), .FINE_W(FINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .load(load), .load_val(load_val),
  .norm_req(norm_req), .int_q(int_q), .p_q(p_q), .tune_word(tune_word),
  .fine_dac(fine_dac), .coarse_dac(coarse_dac), .dac_renorm(dac_renorm)
);

// File: tb/pll_tune_filter_tb.sv
module pll_tune_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic signed [15:0] err = '0;
  logic [3:0]  igain_sel = 4'd8;
  logic [3:0]  pgain_sel = 4'd8;
  logic        hold = 1'b0;
  logic        load = 1'b0;
  logic [31:0] load_val = '0;
  logic        norm_req = 1'b0;
  logic [23:0] tune_word;
  logic [15:0] fine_dac;
  logic [15:0] coarse_dac;
  logic        dac_renorm;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    string       tag;
    longint      tune;
    longint      fine;
    longint      coarse;
    bit          ren;
  } exp_t;
  exp_t sb[$];

  // Reference state kept as plain integers.
  longint m_int = 0, m_p = 0, m_tune = 0, m_fine = 32768, m_coarse = 65408;
  bit     m_loadq = 0, m_ren = 0;

  always #10 clk = ~clk;

  pll_tune_filter u_dut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err(err),
    .igain_sel(igain_sel), .pgain_sel(pgain_sel), .hold(hold), .load(load),
    .load_val(load_val), .norm_req(norm_req), .tune_word(tune_word),
    .fine_dac(fine_dac), .coarse_dac(coarse_dac), .dac_renorm(dac_renorm)
  );

  function automatic longint bgain(longint e, int c);
    if (c >= 8) return e * (64'sd1 << (c - 8));
    return e >>> (8 - c);
  endfunction

  function automatic longint clip(longint v, longint hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic chk(string tag, string what, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Driver: apply one cycle of inputs and push the outputs expected after that edge.
  task automatic step(bit v, int e, int ig, int pg, bit h, bit ld, longint lv,
                      bit nr, string tag);
    longint d;
    exp_t   x;
    @(negedge clk);
    err_valid = v; err = 16'(e); igain_sel = 4'(ig); pgain_sel = 4'(pg);
    hold = h; load = ld; load_val = 32'(lv); norm_req = nr;
    d = ((m_tune - m_coarse * 256) % 16777216 + 16777216) % 16777216;
    if (nr || m_loadq || d > 65535) begin
      m_fine   = 32768 + (m_tune % 256);
      m_coarse = ((m_tune / 256) - 128 + 65536) % 65536;
      m_ren    = 1;
    end else begin
      m_fine = d;
      m_ren  = 0;
    end
    m_loadq = ld;
    if (ld) m_int = lv;
    else if (v && !h) m_int = clip(m_int + bgain(e, ig), 64'hFFFF_FFFF);
    if (h) m_p = 0;
    else if (v && !ld) m_p = bgain(e, pg);
    m_tune = clip((m_int >>> 8) + m_p, 64'hFF_FFFF);
    x.tag = tag; x.tune = m_tune; x.fine = m_fine; x.coarse = m_coarse; x.ren = m_ren;
    sb.push_back(x);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 8, 8, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compare after each edge, away from it.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        chk(x.tag, "tune_word", longint'(tune_word), x.tune);
        chk(x.tag, "fine_dac", longint'(fine_dac), x.fine);
        chk(x.tag, "coarse_dac", longint'(coarse_dac), x.coarse);
        chk(x.tag, "dac_renorm", longint'(dac_renorm), longint'(x.ren));
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R10", "tune_word", longint'(tune_word), 0);
    chk("R10", "fine_dac", longint'(fine_dac), 32768);
    chk("R10", "coarse_dac", longint'(coarse_dac), 65408);
    chk("R10", "dac_renorm", longint'(dac_renorm), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 R5 R8: unity gains, small steps tracked by the fine DAC only.
    step(1, 256, 8, 8, 0, 0, 0, 0, "R4_R5");
    step(1, -100, 8, 8, 0, 0, 0, 0, "R8_track");
    step(1, 1000, 9, 10, 0, 0, 0, 0, "R1_up");
    idle(2, "R8_idle");
    // R2: preload, then forced normalise.
    step(0, 0, 8, 8, 0, 1, 64'h0123_4500, 0, "R2_load");
    step(0, 0, 8, 8, 0, 0, 0, 0, "R2_norm");
    idle(1, "R7_after");
    // R1: small gains, floor rounding of negative errors.
    step(1, -1, 0, 0, 0, 0, 0, 0, "R1_floor");
    step(1, -300, 3, 7, 0, 0, 0, 0, "R1_down");
    step(1, 12345, 15, 2, 0, 0, 0, 0, "R1_max");
    // R3: hold ignores samples and clears the proportional term.
    step(1, 30000, 15, 15, 1, 0, 0, 0, "R3_hold");
    step(1, -30000, 15, 15, 1, 0, 0, 0, "R3_hold2");
    idle(1, "R3_release");
    // R9: big proportional kick forces automatic normalisation, and back.
    step(1, 32767, 8, 15, 0, 0, 0, 0, "R9_auto");
    idle(1, "R9_auto2");
    step(0, 0, 8, 8, 1, 0, 0, 0, "R9_drop");
    idle(1, "R9_drop2");
    step(0, 0, 8, 8, 0, 0, 0, 1, "R9_req");
    step(1, 700, 8, 8, 0, 0, 0, 1, "R9_req2");
    idle(1, "R7_mid");
    // R4 R5: saturation at the top.
    step(0, 0, 8, 8, 0, 1, 64'hFFFF_FF00, 0, "R4_load_hi");
    step(1, 32767, 15, 15, 0, 0, 0, 0, "R4_sat_hi");
    step(1, 5, 8, 8, 0, 0, 0, 0, "R5_sat_hi");
    // R4 R5: saturation at the bottom.
    step(0, 0, 8, 8, 0, 1, 64'h0000_0200, 0, "R4_load_lo");
    step(1, -32768, 15, 15, 0, 0, 0, 0, "R4_sat_lo");
    step(1, -20, 8, 8, 0, 0, 0, 0, "R5_sat_lo");
    idle(3, "R6_settle");
    // R6: alternating signs at mid gains.
    for (int i = 0; i < 20; i++)
      step(1, (i % 2 == 0) ? 4000 + i * 37 : -3500 - i * 11, 6 + i % 5, 9 + i % 4,
           0, 0, 0, 0, "R6_mix");
    idle(3, "R6_end");

    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule